// File: doc/BRIEF.md
# Multilevel Cell Read Decoder

This block turns one digitized resistance reading of a four-level memory cell into two bits. The reading arrives as an unsigned code whose unit is one megaohm. Each cell stores one of four combined states. The upper bit of the state is the stored memory value. The lower bit is a logic value that in-place logic operations may change. In-place logic operations never move a cell between the two memory regions. A low-resistance region holds memory 1 and a high-resistance region holds memory 0. Inside each region, the less resistive level means logic 1.

A read can run in one of two modes. A memory-only read performs a single coarse compare against the memory threshold and returns its result one cycle after the request. A full read adds a second compare, which needs one more cycle. That second compare uses the low-region logic threshold when the coarse result was memory 1, and the high-region logic threshold otherwise. All three thresholds are writable registers. An out-of-band flag marks any code that lies outside the four programmed-resistance windows. The two bits are still decoded from the thresholds in that case.

Top module: `mlc_read_decoder`

## Requirements
- R1: After reset, `out_valid` is 0 and `in_ready` is 1. The thresholds are 225 (memory), 100 (low-region logic) and 310 (high-region logic).
- R2: The memory bit is 1 when the code is strictly below the memory threshold, and 0 when the code is at or above it.
- R3: On a full read, the logic bit is 1 when the code is strictly below the region's logic threshold. The low-region threshold applies when the memory bit is 1, and the high-region threshold applies when it is 0.
- R4: A memory-only read accepted at a clock edge raises `out_valid` for exactly one cycle after that edge, with `out_full` = 0 and `out_logic` = 0.
- R5: A full read accepted at a clock edge holds `in_ready` low and `out_valid` low in the next cycle. It raises `out_valid` with `out_full` = 1 one cycle later. A request made while `in_ready` is low is dropped and produces no result.
- R6: `out_oob` is 1 unless the code lies in one of the inclusive windows 20..33, 170..190, 260..280 or 340..360. The memory and logic bits are produced as usual either way.
- R7: A write with `cfg_sel` = 0 sets the memory threshold, 1 sets the low-region logic threshold and 2 sets the high-region logic threshold. Value 3 changes nothing. The new value governs later reads.
- R8: The state encoding is {memory, logic}. Codes in 20..33, 170..190, 260..280 and 340..360 decode to 11, 10, 01 and 00 respectively under the reset thresholds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Threshold write strobe |
| cfg_sel | input | 2 | Threshold select: 0 memory, 1 low-region logic, 2 high-region logic |
| cfg_data | input | CODE_W | Threshold value written |
| rd_start | input | 1 | Read request, taken when `in_ready` is 1 |
| rd_full | input | 1 | 1 for a full read, 0 for memory-only |
| rd_code | input | CODE_W | Resistance code in megaohms |
| in_ready | output | 1 | Block can take a read request this cycle |
| out_valid | output | 1 | One-cycle result strobe |
| out_full | output | 1 | Result came from a full read |
| out_mem | output | 1 | Decoded memory bit |
| out_logic | output | 1 | Decoded logic bit (0 for memory-only reads) |
| out_oob | output | 1 | Code lies outside every valid window |

## Verification
The assertions assume that the thresholds are not rewritten while a full read is between its two compares. They also assume that a threshold write and a read request never share a clock edge, because the ordering between the two is otherwise undefined for the checks. The bench keeps to this by issuing writes only while the block is idle and the results have drained. Read requests are driven on the falling edge, in separate cycles from the writes. The only request made while `in_ready` is low is the deliberate one that tests dropping.

// File: rtl/mlc_read_decoder.sv
module mlc_read_decoder #(
  parameter int CODE_W   = 10,
  parameter int THR_MEM0 = 225,
  parameter int THR_LO0  = 100,
  parameter int THR_HI0  = 310,
  parameter int W11_MIN  = 20,
  parameter int W11_MAX  = 33,
  parameter int W10_MIN  = 170,
  parameter int W10_MAX  = 190,
  parameter int W01_MIN  = 260,
  parameter int W01_MAX  = 280,
  parameter int W00_MIN  = 340,
  parameter int W00_MAX  = 360
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_wr,
  input  logic [1:0]        cfg_sel,
  input  logic [CODE_W-1:0] cfg_data,
  input  logic              rd_start,
  input  logic              rd_full,
  input  logic [CODE_W-1:0] rd_code,
  output logic              in_ready,
  output logic              out_valid,
  output logic              out_full,
  output logic              out_mem,
  output logic              out_logic,
  output logic              out_oob
);
  localparam logic [CODE_W-1:0] A_LO = CODE_W'(W11_MIN);
  localparam logic [CODE_W-1:0] A_HI = CODE_W'(W11_MAX);
  localparam logic [CODE_W-1:0] B_LO = CODE_W'(W10_MIN);
  localparam logic [CODE_W-1:0] B_HI = CODE_W'(W10_MAX);
  localparam logic [CODE_W-1:0] C_LO = CODE_W'(W01_MIN);
  localparam logic [CODE_W-1:0] C_HI = CODE_W'(W01_MAX);
  localparam logic [CODE_W-1:0] D_LO = CODE_W'(W00_MIN);
  localparam logic [CODE_W-1:0] D_HI = CODE_W'(W00_MAX);

  logic [CODE_W-1:0] thr_mem, thr_lo, thr_hi;
  logic              pend;
  logic [CODE_W-1:0] held_code;
  logic              held_mem, held_oob;

  wire take     = rd_start && in_ready;
  wire coarse   = rd_code < thr_mem;
  wire in_band  = (rd_code >= A_LO && rd_code <= A_HI) ||
                  (rd_code >= B_LO && rd_code <= B_HI) ||
                  (rd_code >= C_LO && rd_code <= C_HI) ||
                  (rd_code >= D_LO && rd_code <= D_HI);
  wire [CODE_W-1:0] fine_thr = held_mem ? thr_lo : thr_hi;
  wire fine     = held_code < fine_thr;

  assign in_ready = !pend;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      thr_mem <= CODE_W'(THR_MEM0);
      thr_lo  <= CODE_W'(THR_LO0);
      thr_hi  <= CODE_W'(THR_HI0);
    end else if (cfg_wr) begin
      case (cfg_sel)
        2'd0:    thr_mem <= cfg_data;
        2'd1:    thr_lo  <= cfg_data;
        2'd2:    thr_hi  <= cfg_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend      <= 1'b0;
      held_code <= '0;
      held_mem  <= 1'b0;
      held_oob  <= 1'b0;
    end else if (take && rd_full) begin
      pend      <= 1'b1;
      held_code <= rd_code;
      held_mem  <= coarse;
      held_oob  <= !in_band;
    end else begin
      pend      <= 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      out_full  <= 1'b0;
      out_mem   <= 1'b0;
      out_logic <= 1'b0;
      out_oob   <= 1'b0;
    end else if (pend) begin
      out_valid <= 1'b1;
      out_full  <= 1'b1;
      out_mem   <= held_mem;
      out_logic <= fine;
      out_oob   <= held_oob;
    end else if (take && !rd_full) begin
      out_valid <= 1'b1;
      out_full  <= 1'b0;
      out_mem   <= coarse;
      out_logic <= 1'b0;
      out_oob   <= !in_band;
    end else begin
      out_valid <= 1'b0;
    end
  end

  assert_reset_idle_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> in_ready && !out_valid);

  assert_coarse_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rd_full && rd_code < thr_mem && !cfg_wr) |=> out_mem);

  assert_coarse_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rd_full && rd_code >= thr_mem && !cfg_wr) |=> !out_mem);

  assert_memonly_result_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rd_full) |=> out_valid && !out_full && !out_logic);

  assert_full_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rd_full) |=> !out_valid && !in_ready);

  assert_full_done_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (take && rd_full) |=> ##1 (out_valid && out_full && in_ready));

  assert_inband_clear_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (take && !rd_full && rd_code >= A_LO && rd_code <= A_HI) |=> !out_oob);

  assert_cfg_mem_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == 2'd0) |=> thr_mem == $past(cfg_data));

  assert_cfg_none_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (cfg_wr && cfg_sel == 2'd3) |=> $stable(thr_mem) && $stable(thr_lo) && $stable(thr_hi));
endmodule

// File: tb/mlc_read_decoder_test.sv
module mlc_read_decoder_test;
  localparam int CW = 10;
  localparam int NV = 20;

  // vector: {full, code[9:0], exp_mem, exp_logic, exp_oob}
  localparam logic [13:0] VEC [NV] = '{
    {1'b1, 10'd28,   3'b110}, {1'b1, 10'd180,  3'b100},
    {1'b1, 10'd270,  3'b010}, {1'b1, 10'd350,  3'b000},
    {1'b1, 10'd20,   3'b110}, {1'b1, 10'd33,   3'b110},
    {1'b1, 10'd34,   3'b111}, {1'b1, 10'd169,  3'b101},
    {1'b1, 10'd190,  3'b100}, {1'b1, 10'd191,  3'b101},
    {1'b1, 10'd224,  3'b101}, {1'b1, 10'd225,  3'b011},
    {1'b1, 10'd260,  3'b010}, {1'b1, 10'd310,  3'b001},
    {1'b1, 10'd361,  3'b001}, {1'b1, 10'd1023, 3'b001},
    {1'b0, 10'd180,  3'b100}, {1'b0, 10'd28,   3'b100},
    {1'b0, 10'd350,  3'b000}, {1'b0, 10'd500,  3'b001}
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [1:0] cfg_sel = '0;
  logic [CW-1:0] cfg_data = '0;
  logic rd_start = 1'b0;
  logic rd_full = 1'b0;
  logic [CW-1:0] rd_code = '0;
  logic in_ready, out_valid, out_full, out_mem, out_logic, out_oob;

  int checks = 0;
  int fails = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  mlc_read_decoder uut (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel), .cfg_data(cfg_data),
    .rd_start(rd_start), .rd_full(rd_full), .rd_code(rd_code), .in_ready(in_ready),
    .out_valid(out_valid), .out_full(out_full), .out_mem(out_mem),
    .out_logic(out_logic), .out_oob(out_oob)
  );

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic write_thr(input logic [1:0] sel, input int val);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_sel = sel; cfg_data = CW'(val);
    @(negedge clk);
    cfg_wr = 1'b0;
    @(negedge clk);
  endtask

  task automatic do_read(input string req, input logic full, input int code,
                         input logic em, input logic el, input logic eo);
    @(negedge clk);
    rd_start = 1'b1; rd_full = full; rd_code = CW'(code);
    @(negedge clk);
    rd_start = 1'b0;
    if (full) begin
      check({req, " R5 gap"}, {6'd0, out_valid, in_ready}, 8'h00);
      @(negedge clk);
    end
    check({req, " result"}, {3'd0, out_valid, out_full, out_mem, out_logic, out_oob},
          {3'd0, 1'b1, full, em, el, eo});
    @(negedge clk);
    check({req, " R4 single strobe"}, {7'd0, out_valid}, 8'h00);
  endtask

  initial begin
    #(5.0 * 100000);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog expired: got hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R1 reset outputs", {6'd0, out_valid, in_ready}, 8'h01);
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 idle after release", {6'd0, out_valid, in_ready}, 8'h01);

    // R2 R3 R6 R8 table walk under reset thresholds (R1)
    for (int i = 0; i < NV; i++) begin
      do_read($sformatf("R2/R3/R6/R8 vec%0d", i), VEC[i][13], int'(VEC[i][12:3]),
              VEC[i][2], VEC[i][1], VEC[i][0]);
    end

    // R5: request during busy cycle is dropped
    @(negedge clk);
    rd_start = 1'b1; rd_full = 1'b1; rd_code = CW'(28);
    @(negedge clk);
    check("R5 busy", {6'd0, out_valid, in_ready}, 8'h00);
    rd_full = 1'b0; rd_code = CW'(350);
    @(negedge clk);
    rd_start = 1'b0;
    check("R5 first result kept", {4'd0, out_valid, out_full, out_mem, out_logic}, 8'h0F);
    @(negedge clk);
    check("R5 dropped request", {7'd0, out_valid}, 8'h00);

    // R7: threshold writes
    write_thr(2'd0, 300);
    do_read("R7 mem thr", 1'b1, 280, 1'b1, 1'b0, 1'b0);
    write_thr(2'd1, 290);
    do_read("R7 low thr", 1'b1, 280, 1'b1, 1'b1, 1'b0);
    write_thr(2'd2, 400);
    write_thr(2'd0, 225);
    do_read("R7 high thr", 1'b1, 350, 1'b0, 1'b1, 1'b0);
    write_thr(2'd3, 5);
    do_read("R7 sel3 ignored low", 1'b1, 180, 1'b1, 1'b1, 1'b0);
    do_read("R7 sel3 ignored high", 1'b1, 350, 1'b0, 1'b1, 1'b0);
    do_read("R7 sel3 mem", 1'b0, 224, 1'b1, 1'b0, 1'b1);

    // R1: reset restores defaults
    @(negedge clk);
    rst_n = 1'b0;
    @(negedge clk);
    rst_n = 1'b1;
    do_read("R1 defaults restored", 1'b1, 180, 1'b1, 1'b0, 1'b0);
    do_read("R1 default high", 1'b1, 350, 1'b0, 1'b0, 1'b0);

    finished = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule